// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between an on-chip requester and an external asynchronous NOR flash with a 16-bit data bus. The requester hands it one operation at a time over a valid/ready pair: read a word from the array, program a word, erase a sector, erase the whole device, or identify the device. For each operation the block produces the unlock and command write cycles the flash expects. It then learns that the flash has finished, either by reading back until the status stops toggling or by waiting a fixed time. At the end it pulses one response. Every address the requester supplies is a word address. The block places it on the byte-addressed bus shifted left by one.

The control is one state machine. Its states are: ST_IDLE (ready, waiting for a request); ST_CMD (issuing the command writes for program, erase and identify entry); ST_SETTLE_IN (settle wait after identify entry); ST_ID_READ (reading the two identification words); ST_ID_EXIT (issuing the identify exit writes); ST_SETTLE_OUT (settle wait after exit); ST_POLL (paired status reads after a program); ST_ERASE_WAIT (fixed erase wait); ST_ARRAY_READ (a single array read); and ST_RESP (one-clock response). The transitions are as follows. ST_IDLE goes to ST_ARRAY_READ, ST_CMD or ST_RESP, chosen by the operation code. ST_CMD goes to ST_POLL, ST_ERASE_WAIT or ST_SETTLE_IN after its last write. ST_SETTLE_IN leads to ST_ID_READ, then ST_ID_EXIT, then ST_SETTLE_OUT, then ST_RESP. ST_POLL, ST_ERASE_WAIT and ST_ARRAY_READ each go to ST_RESP, and ST_RESP returns to ST_IDLE. A separate bus-cycle engine shapes each individual read or write strobe, and a wait timer counts the fixed delays.

Top module: `nor_cmd_seq`

## Requirements
- R1: Operation codes on req_op are 0 read, 1 program, 2 sector erase, 3 chip erase and 4 identify; codes 5 to 7 are accepted and answered with rsp_done after zero bus cycles. A request is taken when req_valid and req_ready are both high. req_ready is low from the next cycle until after the response pulse, and requests presented meanwhile are ignored.
- R2: In a write cycle nor_ce_n is low throughout. Address and data are driven (nor_dq_oe high) for SETUP_CLK clocks, then nor_we_n is low for PULSE_CLK clocks, then address and data are held for HOLD_CLK clocks. In a read cycle nor_ce_n and nor_oe_n are low for READ_CLK clocks. nor_ce_n is high for at least one clock between cycles. nor_we_n and nor_oe_n are never low together, and nor_dq_oe is never high while nor_oe_n is low.
- R3: The bus address nor_addr equals the word address shifted left by one bit.
- R4: A program issues writes (word 0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x00A0) and then (target, data).
- R5: After the program writes, the target is read in pairs. Equal values in a pair end the operation with rsp_done. POLL_TRIES unequal pairs end it with rsp_timeout instead.
- R6: A sector erase issues (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55) and (sector address, 0x30), then waits SECTOR_WAIT_CLK clocks.
- R7: A chip erase issues the same first five writes, then (0x5555, 0x10), and waits CHIP_WAIT_CLK clocks.
- R8: Identify issues writes of 0xAA, 0x55 and 0x90 to words 0x5555, 0x2AAA and 0x5555, and waits SETTLE_CLK. It then reads word 0 (manufacturer) and word 1 (device), issues 0xAA, 0x55 and 0xF0 to the same three words, and waits SETTLE_CLK. rsp_rdata returns the device code.
- R9: rsp_bad_id is high with the identify rsp_done when the manufacturer is not 0x00BF, or when the device code is none of 0x234B, 0x234A, 0x235B, 0x235A.
- R10: A read performs exactly one read cycle at the request address and returns the word on rsp_rdata.
- R11: rsp_done and rsp_timeout are one-clock pulses, never together, due exactly as stated under Verification.
- R12: During and right after reset, nor_ce_n, nor_we_n and nor_oe_n are high, nor_dq_oe is low, req_ready is high and no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Word address (target, sector, or read address) |
| req_data | input | 16 | Word to program |
| rsp_done | output | 1 | Operation finished, one clock |
| rsp_timeout | output | 1 | Program polling exhausted, one clock |
| rsp_bad_id | output | 1 | Identification not recognised, valid with rsp_done |
| rsp_rdata | output | 16 | Read word or device code |
| nor_addr | output | AW+1 | Flash bus address |
| nor_dq_out | output | 16 | Flash write data |
| nor_dq_oe | output | 1 | Drive enable for write data |
| nor_dq_in | input | 16 | Flash read data |
| nor_ce_n | output | 1 | Chip enable, active low |
| nor_we_n | output | 1 | Write enable, active low |
| nor_oe_n | output | 1 | Output enable, active low |

## Verification
The response cycle is counted from the accepting clock edge. Let W = 1+SETUP_CLK+PULSE_CLK+HOLD_CLK per write and D = 1+READ_CLK per read. A read answers after D cycles. A program answers after 4W+2kD, where k is the number of read pairs used. Sector and chip erase answer after 6W plus their wait. Identify answers after 6W+2D+2·SETTLE_CLK, and an unknown code answers after 0 cycles. The bench drives on falling edges. It counts rising edges after acceptance and samples on the falling edge that follows, so each latency is compared as an exact number. It also checks that the pulse is gone one cycle later.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int DATA_W = 16;

    localparam logic [2:0] OP_READ  = 3'd0;
    localparam logic [2:0] OP_PROG  = 3'd1;
    localparam logic [2:0] OP_SECT  = 3'd2;
    localparam logic [2:0] OP_CHIP  = 3'd3;
    localparam logic [2:0] OP_IDENT = 3'd4;

    localparam logic [31:0] KEY_ADDR_A = 32'h0000_5555;
    localparam logic [31:0] KEY_ADDR_B = 32'h0000_2AAA;
    localparam logic [DATA_W-1:0] MFR_EXPECTED = 16'h00BF;

    typedef enum logic [2:0] {
        SEQ_PROG,
        SEQ_SECT,
        SEQ_CHIP,
        SEQ_ID_IN,
        SEQ_ID_OUT
    } seq_e;

    typedef struct packed {
        logic [31:0]       waddr;
        logic [DATA_W-1:0] wdata;
    } bus_wr_t;

    // index of the final write in each command sequence
    function automatic logic [2:0] seq_last(input seq_e kind);
        case (kind)
            SEQ_PROG:            return 3'd3;
            SEQ_SECT, SEQ_CHIP:  return 3'd5;
            default:             return 3'd2;
        endcase
    endfunction

    // the write issued at a given step of a command sequence
    function automatic bus_wr_t seq_step(input seq_e kind, input logic [2:0] idx,
                                         input logic [31:0] tgt,
                                         input logic [DATA_W-1:0] tdata);
        bus_wr_t w;
        logic [DATA_W-1:0] third;
        case (kind)
            SEQ_PROG:   third = 16'h00A0;
            SEQ_ID_IN:  third = 16'h0090;
            SEQ_ID_OUT: third = 16'h00F0;
            default:    third = 16'h0080;
        endcase
        case (idx)
            3'd0:    w = '{KEY_ADDR_A, 16'h00AA};
            3'd1:    w = '{KEY_ADDR_B, 16'h0055};
            3'd2:    w = '{KEY_ADDR_A, third};
            3'd3:    w = (kind == SEQ_PROG) ? '{tgt, tdata} : '{KEY_ADDR_A, 16'h00AA};
            3'd4:    w = '{KEY_ADDR_B, 16'h0055};
            default: w = (kind == SEQ_SECT) ? '{tgt, 16'h0030} : '{KEY_ADDR_A, 16'h0010};
        endcase
        return w;
    endfunction

    function automatic logic id_known(input logic [DATA_W-1:0] mfr,
                                      input logic [DATA_W-1:0] dev);
        logic dev_ok;
        dev_ok = (dev == 16'h234B) || (dev == 16'h234A) ||
                 (dev == 16'h235B) || (dev == 16'h235A);
        return (mfr == MFR_EXPECTED) && dev_ok;
    endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int SETUP_CLK = 2,
    parameter int PULSE_CLK = 3,
    parameter int HOLD_CLK  = 2,
    parameter int READ_CLK  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_go,
    input  logic          cyc_write,
    input  logic [AW-1:0] cyc_waddr,
    input  logic [DW-1:0] cyc_wdata,
    output logic          cyc_done,
    output logic [AW:0]   bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    output logic          bus_ce_n,
    output logic          bus_we_n,
    output logic          bus_oe_n
);
    localparam int M_A  = (SETUP_CLK > PULSE_CLK) ? SETUP_CLK : PULSE_CLK;
    localparam int M_B  = (HOLD_CLK > READ_CLK) ? HOLD_CLK : READ_CLK;
    localparam int M_AB = (M_A > M_B) ? M_A : M_B;
    localparam int CW   = $clog2(M_AB + 1);

    typedef enum logic [2:0] {E_IDLE, E_SETUP, E_PULSE, E_HOLD, E_READ} eng_e;

    eng_e          st_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= E_IDLE;
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            unique case (st_q)
                E_IDLE: if (cyc_go) begin
                    addr_q <= cyc_waddr;
                    data_q <= cyc_wdata;
                    st_q   <= cyc_write ? E_SETUP : E_READ;
                    cnt_q  <= cyc_write ? CW'(SETUP_CLK - 1) : CW'(READ_CLK - 1);
                end
                E_SETUP: if (cnt_q == '0) begin
                    st_q  <= E_PULSE;
                    cnt_q <= CW'(PULSE_CLK - 1);
                end else cnt_q <= cnt_q - 1'b1;
                E_PULSE: if (cnt_q == '0) begin
                    st_q  <= E_HOLD;
                    cnt_q <= CW'(HOLD_CLK - 1);
                end else cnt_q <= cnt_q - 1'b1;
                E_HOLD, E_READ: if (cnt_q == '0) st_q <= E_IDLE;
                                else cnt_q <= cnt_q - 1'b1;
                default: st_q <= E_IDLE;
            endcase
        end
    end

    assign cyc_done = ((st_q == E_HOLD) || (st_q == E_READ)) && (cnt_q == '0);
    assign bus_addr = {addr_q, 1'b0};
    assign bus_dout = data_q;
    assign bus_doe  = (st_q == E_SETUP) || (st_q == E_PULSE) || (st_q == E_HOLD);
    assign bus_ce_n = (st_q == E_IDLE);
    assign bus_we_n = (st_q != E_PULSE);
    assign bus_oe_n = (st_q != E_READ);

endmodule

// File: rtl/nor_wait_timer.sv
module nor_wait_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign fire = run && (cnt_q == limit - CNT_W'(1));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW              = 20,
    parameter int SETUP_CLK       = 2,
    parameter int PULSE_CLK       = 3,
    parameter int HOLD_CLK        = 2,
    parameter int READ_CLK        = 3,
    parameter int SETTLE_CLK      = 1000,
    parameter int SECTOR_WAIT_CLK = 2500000,
    parameter int CHIP_WAIT_CLK   = 5000000,
    parameter int POLL_TRIES      = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    output logic          rsp_done,
    output logic          rsp_timeout,
    output logic          rsp_bad_id,
    output logic [15:0]   rsp_rdata,
    output logic [AW:0]   nor_addr,
    output logic [15:0]   nor_dq_out,
    output logic          nor_dq_oe,
    input  logic [15:0]   nor_dq_in,
    output logic          nor_ce_n,
    output logic          nor_we_n,
    output logic          nor_oe_n
);
    localparam int W_A      = (SECTOR_WAIT_CLK > CHIP_WAIT_CLK) ? SECTOR_WAIT_CLK : CHIP_WAIT_CLK;
    localparam int W_MAX    = (W_A > SETTLE_CLK) ? W_A : SETTLE_CLK;
    localparam int CNT_W    = $clog2(W_MAX + 1);
    localparam int TW       = $clog2(POLL_TRIES + 1);
    localparam logic [TW-1:0] LAST_TRY = TW'(POLL_TRIES - 1);

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_SETTLE_IN, ST_ID_READ, ST_ID_EXIT,
        ST_SETTLE_OUT, ST_POLL, ST_ERASE_WAIT, ST_ARRAY_READ, ST_RESP
    } state_e;

    state_e         state_q, state_d;
    logic [2:0]     idx_q, op_q;
    logic [AW-1:0]  addr_q;
    logic [15:0]    data_q, poll_prev_q, mfr_q, rdata_q;
    logic           poll_second_q, bad_q, to_q;
    logic [TW-1:0]  tries_q;

    logic           cyc_go, cyc_write, cyc_done;
    logic [AW-1:0]  cyc_waddr;
    logic [15:0]    cyc_wdata;
    logic           tmr_run, tmr_fire;
    logic [CNT_W-1:0] tmr_limit;
    seq_e           seq_kind;
    logic [2:0]     last_idx;
    bus_wr_t        step;
    logic           poll_match;

    always_comb begin
        if (state_q == ST_ID_EXIT) seq_kind = SEQ_ID_OUT;
        else begin
            case (op_q)
                OP_PROG: seq_kind = SEQ_PROG;
                OP_SECT: seq_kind = SEQ_SECT;
                OP_CHIP: seq_kind = SEQ_CHIP;
                default: seq_kind = SEQ_ID_IN;
            endcase
        end
    end

    assign last_idx   = seq_last(seq_kind);
    assign step       = seq_step(seq_kind, idx_q, 32'(addr_q), data_q);
    assign poll_match = (nor_dq_in == poll_prev_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                case (req_op)
                    OP_READ:                            state_d = ST_ARRAY_READ;
                    OP_PROG, OP_SECT, OP_CHIP, OP_IDENT: state_d = ST_CMD;
                    default:                            state_d = ST_RESP;
                endcase
            end
            ST_CMD: if (cyc_done && idx_q == last_idx) begin
                case (seq_kind)
                    SEQ_PROG:  state_d = ST_POLL;
                    SEQ_ID_IN: state_d = ST_SETTLE_IN;
                    default:   state_d = ST_ERASE_WAIT;
                endcase
            end
            ST_SETTLE_IN:  if (tmr_fire) state_d = ST_ID_READ;
            ST_ID_READ:    if (cyc_done && idx_q[0]) state_d = ST_ID_EXIT;
            ST_ID_EXIT:    if (cyc_done && idx_q == last_idx) state_d = ST_SETTLE_OUT;
            ST_SETTLE_OUT: if (tmr_fire) state_d = ST_RESP;
            ST_POLL:       if (cyc_done && poll_second_q && (poll_match || tries_q == LAST_TRY))
                               state_d = ST_RESP;
            ST_ERASE_WAIT: if (tmr_fire) state_d = ST_RESP;
            ST_ARRAY_READ: if (cyc_done) state_d = ST_RESP;
            ST_RESP:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cyc_go      = 1'b0;
        cyc_write   = 1'b0;
        cyc_waddr   = addr_q;
        cyc_wdata   = data_q;
        tmr_run     = 1'b0;
        tmr_limit   = CNT_W'(SETTLE_CLK);
        req_ready   = (state_q == ST_IDLE);
        rsp_done    = (state_q == ST_RESP) && !to_q;
        rsp_timeout = (state_q == ST_RESP) && to_q;
        rsp_bad_id  = (state_q == ST_RESP) && bad_q;
        unique case (state_q)
            ST_CMD, ST_ID_EXIT: begin
                cyc_go    = 1'b1;
                cyc_write = 1'b1;
                cyc_waddr = step.waddr[AW-1:0];
                cyc_wdata = step.wdata;
            end
            ST_ID_READ: begin
                cyc_go    = 1'b1;
                cyc_waddr = AW'(idx_q[0]);
            end
            ST_POLL, ST_ARRAY_READ: cyc_go = 1'b1;
            ST_SETTLE_IN, ST_SETTLE_OUT: tmr_run = 1'b1;
            ST_ERASE_WAIT: begin
                tmr_run   = 1'b1;
                tmr_limit = (op_q == OP_CHIP) ? CNT_W'(CHIP_WAIT_CLK) : CNT_W'(SECTOR_WAIT_CLK);
            end
            default: ;
        endcase
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0; op_q <= '0; addr_q <= '0; data_q <= '0;
            poll_prev_q <= '0; mfr_q <= '0; rdata_q <= '0;
            poll_second_q <= 1'b0; bad_q <= 1'b0; to_q <= 1'b0; tries_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q <= req_op; addr_q <= req_addr; data_q <= req_data;
                    idx_q <= '0; poll_second_q <= 1'b0; tries_q <= '0;
                    bad_q <= 1'b0; to_q <= 1'b0;
                end
                ST_CMD, ST_ID_EXIT: if (cyc_done)
                    idx_q <= (idx_q == last_idx) ? 3'd0 : idx_q + 3'd1;
                ST_ID_READ: if (cyc_done) begin
                    if (!idx_q[0]) begin
                        mfr_q <= nor_dq_in;
                        idx_q <= 3'd1;
                    end else begin
                        rdata_q <= nor_dq_in;
                        bad_q   <= !id_known(mfr_q, nor_dq_in);
                        idx_q   <= 3'd0;
                    end
                end
                ST_POLL: if (cyc_done) begin
                    if (!poll_second_q) begin
                        poll_prev_q   <= nor_dq_in;
                        poll_second_q <= 1'b1;
                    end else begin
                        poll_second_q <= 1'b0;
                        rdata_q       <= nor_dq_in;
                        if (!poll_match) begin
                            if (tries_q == LAST_TRY) to_q <= 1'b1;
                            else                     tries_q <= tries_q + 1'b1;
                        end
                    end
                end
                ST_ARRAY_READ: if (cyc_done) rdata_q <= nor_dq_in;
                default: ;
            endcase
        end
    end

    assign rsp_rdata = rdata_q;

    nor_bus_cycle #(
        .AW(AW), .DW(DATA_W), .SETUP_CLK(SETUP_CLK), .PULSE_CLK(PULSE_CLK),
        .HOLD_CLK(HOLD_CLK), .READ_CLK(READ_CLK)
    ) u_cycle (
        .clk(clk), .rst_n(rst_n), .cyc_go(cyc_go), .cyc_write(cyc_write),
        .cyc_waddr(cyc_waddr), .cyc_wdata(cyc_wdata), .cyc_done(cyc_done),
        .bus_addr(nor_addr), .bus_dout(nor_dq_out), .bus_doe(nor_dq_oe),
        .bus_ce_n(nor_ce_n), .bus_we_n(nor_we_n), .bus_oe_n(nor_oe_n)
    );

    nor_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmr_limit), .fire(tmr_fire)
    );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          rsp_timeout,
    input logic          rsp_bad_id,
    input logic [AW:0]   nor_addr,
    input logic [15:0]   nor_dq_out,
    input logic          nor_dq_oe,
    input logic          nor_ce_n,
    input logic          nor_we_n,
    input logic          nor_oe_n
);
    // R2
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nor_we_n && !nor_oe_n));
    // R2
    strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nor_ce_n |-> (nor_we_n && nor_oe_n && !nor_dq_oe));
    // R2
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nor_dq_oe |-> nor_oe_n);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nor_we_n && !$past(nor_we_n)) |-> ($stable(nor_addr) && $stable(nor_dq_out)));
    // R11
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_timeout) |=> !(rsp_done || rsp_timeout));
    // R11
    rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_timeout));
    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R1
    rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_timeout) |=> req_ready);
    // R9
    bad_id_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bad_id |-> rsp_done);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_bad_id(rsp_bad_id),
    .nor_addr(nor_addr), .nor_dq_out(nor_dq_out), .nor_dq_oe(nor_dq_oe),
    .nor_ce_n(nor_ce_n), .nor_we_n(nor_we_n), .nor_oe_n(nor_oe_n)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb_top;
    localparam int AW = 16;
    localparam int S = 1, P = 2, H = 1, R = 2;
    localparam int SETTLE = 20, SECT_W = 50, CHIP_W = 90, TRIES = 4;
    localparam int WC = 1 + S + P + H;
    localparam int RC = 1 + R;
    localparam int LAT_RD   = RC;
    localparam int LAT_PG1  = 4 * WC + 2 * RC;
    localparam int LAT_PG2  = 4 * WC + 4 * RC;
    localparam int LAT_PTO  = 4 * WC + 2 * TRIES * RC;
    localparam int LAT_SECT = 6 * WC + SECT_W;
    localparam int LAT_CHIP = 6 * WC + CHIP_W;
    localparam int LAT_ID   = 6 * WC + 2 * RC + 2 * SETTLE;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  tog;
        logic        exp_to;
        logic [15:0] exp_lat;
        logic        chk_rd;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [0:NV-1] = '{
        '{3'd0, 16'h0005, 16'h0000, 8'd0,   1'b0, 16'(LAT_RD),   1'b1, 16'h1234},
        '{3'd0, 16'h000A, 16'h0000, 8'd0,   1'b0, 16'(LAT_RD),   1'b1, 16'hA00A},
        '{3'd1, 16'h0003, 16'hBEEF, 8'd0,   1'b0, 16'(LAT_PG1),  1'b0, 16'h0000},
        '{3'd1, 16'h0003, 16'h1357, 8'd2,   1'b0, 16'(LAT_PG2),  1'b0, 16'h0000},
        '{3'd1, 16'h0004, 16'h0F0F, 8'd200, 1'b1, 16'(LAT_PTO),  1'b0, 16'h0000},
        '{3'd2, 16'h0800, 16'h0000, 8'd0,   1'b0, 16'(LAT_SECT), 1'b0, 16'h0000},
        '{3'd3, 16'h0000, 16'h0000, 8'd0,   1'b0, 16'(LAT_CHIP), 1'b0, 16'h0000},
        '{3'd4, 16'h0000, 16'h0000, 8'd0,   1'b0, 16'(LAT_ID),   1'b1, 16'h234B},
        '{3'd6, 16'h0000, 16'h0000, 8'd0,   1'b0, 16'd0,         1'b0, 16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic rsp_done, rsp_timeout, rsp_bad_id;
    logic [15:0] rsp_rdata;
    logic [AW:0] nor_addr;
    logic [15:0] nor_dq_out, nor_dq_in;
    logic nor_dq_oe, nor_ce_n, nor_we_n, nor_oe_n;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    nor_cmd_seq #(
        .AW(AW), .SETUP_CLK(S), .PULSE_CLK(P), .HOLD_CLK(H), .READ_CLK(R),
        .SETTLE_CLK(SETTLE), .SECTOR_WAIT_CLK(SECT_W), .CHIP_WAIT_CLK(CHIP_W),
        .POLL_TRIES(TRIES)
    ) dut_i (.*);

    // flash model
    logic [15:0] mem [0:15];
    logic        id_mode = 1'b0;
    logic [15:0] mfr_v = 16'h00BF, dev_v = 16'h234B;
    int          tog = 0;
    logic        phase = 1'b1;
    logic [32:0] log_w [0:15];
    int          log_n = 0, rd_n = 0, ce_rise = 0;
    logic        mon = 1'b0;
    int          we_low = 0, oe_low = 0, wr_nowe = 0;

    always_comb begin
        if (id_mode)
            nor_dq_in = (nor_addr[AW:1] == 0) ? mfr_v :
                        (nor_addr[AW:1] == 1) ? dev_v : 16'h0000;
        else
            nor_dq_in = mem[nor_addr[4:1]] ^ ((tog > 0 && phase) ? 16'h0040 : 16'h0000);
    end

    always @(posedge nor_we_n) if (rst_n) begin
        if (log_n < 16) log_w[log_n] = {nor_addr, nor_dq_out};
        log_n = log_n + 1;
        if (nor_addr == 17'h0AAAA && nor_dq_out == 16'h0090) id_mode = 1'b1;
        if (nor_addr == 17'h0AAAA && nor_dq_out == 16'h00F0) id_mode = 1'b0;
    end

    always @(posedge nor_oe_n) if (rst_n) begin
        rd_n = rd_n + 1;
        if (!id_mode && tog > 0) begin
            tog = tog - 1;
            phase = ~phase;
        end
    end

    always @(posedge nor_ce_n) if (rst_n && mon) ce_rise = ce_rise + 1;

    always @(negedge clk) if (mon) begin
        if (!nor_we_n) we_low = we_low + 1;
        if (!nor_oe_n) oe_low = oe_low + 1;
        if (!nor_ce_n && nor_we_n && nor_dq_oe) wr_nowe = wr_nowe + 1;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] exp_wr(input logic [2:0] op, input int i,
                                           input logic [15:0] a, input logic [15:0] d);
        logic [15:0] wa, wd;
        int j;
        j = (op == 3'd4 && i >= 3) ? i - 3 : i;
        case (j)
            0: begin wa = 16'h5555; wd = 16'h00AA; end
            1: begin wa = 16'h2AAA; wd = 16'h0055; end
            2: begin
                wa = 16'h5555;
                wd = (op == 3'd1) ? 16'h00A0 : (op == 3'd4) ? ((i >= 3) ? 16'h00F0 : 16'h0090) : 16'h0080;
            end
            3: begin
                if (op == 3'd1) begin wa = a; wd = d; end
                else begin wa = 16'h5555; wd = 16'h00AA; end
            end
            4: begin wa = 16'h2AAA; wd = 16'h0055; end
            default: begin
                if (op == 3'd2) begin wa = a; wd = 16'h0030; end
                else begin wa = 16'h5555; wd = 16'h0010; end
            end
        endcase
        return {wa, 1'b0, wd};
    endfunction

    function automatic int exp_nwr(input logic [2:0] op);
        case (op)
            3'd1: return 4;
            3'd2, 3'd3, 3'd4: return 6;
            default: return 0;
        endcase
    endfunction

    int lat_o;
    logic to_o, bad_o;
    logic [15:0] rd_o;

    task automatic run_req(input logic [2:0] op, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        log_n = 0; rd_n = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat_o = 0;
        while (!(rsp_done || rsp_timeout) && lat_o < 3000) begin
            @(posedge clk);
            @(negedge clk);
            lat_o = lat_o + 1;
        end
        to_o = rsp_timeout; bad_o = rsp_bad_id; rd_o = rsp_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'hA000 | 16'(i);
        mem[5] = 16'h1234;
        repeat (3) @(negedge clk);
        // R12: outputs held quiet in reset
        chk(nor_ce_n && nor_we_n && nor_oe_n && !nor_dq_oe, "R12 bus idle in reset",
            {nor_ce_n, nor_we_n, nor_oe_n, nor_dq_oe}, 4'hE);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done && !rsp_timeout, "R12 ready after reset",
            {req_ready, rsp_done, rsp_timeout}, 3'b100);

        // table walk: R1 R3 R4 R5 R6 R7 R8 R10 R11
        for (int v = 0; v < NV; v++) begin
            logic ok;
            tog = int'(VEC[v].tog); phase = 1'b1;
            run_req(VEC[v].op, VEC[v].addr, VEC[v].data);
            chk(lat_o == int'(VEC[v].exp_lat), $sformatf("R11 latency vec %0d", v), lat_o, VEC[v].exp_lat);
            chk(to_o == VEC[v].exp_to, $sformatf("R5 status vec %0d", v), to_o, VEC[v].exp_to);
            if (VEC[v].chk_rd)
                chk(rd_o == VEC[v].exp_rd, $sformatf("R10 R3 R8 rdata vec %0d", v), rd_o, VEC[v].exp_rd);
            ok = (log_n == exp_nwr(VEC[v].op));
            for (int i = 0; i < 16; i++)
                if (i < log_n && log_w[i] != exp_wr(VEC[v].op, i, VEC[v].addr, VEC[v].data)) ok = 1'b0;
            chk(ok, $sformatf("R4 R6 R7 R8 write sequence vec %0d", v), log_n, exp_nwr(VEC[v].op));
            if (VEC[v].op > 3'd4)
                chk(rd_n == 0, "R1 unknown code has no read", rd_n, 0);
            @(negedge clk);
            chk(!rsp_done && !rsp_timeout && req_ready, $sformatf("R11 single pulse vec %0d", v),
                {rsp_done, rsp_timeout, req_ready}, 3'b001);
        end

        // R2: strobe shape during a program that completes on its first pair
        we_low = 0; oe_low = 0; wr_nowe = 0; ce_rise = 0; tog = 0;
        mon = 1'b1;
        run_req(3'd1, 16'h0002, 16'h5A5A);
        mon = 1'b0;
        chk(we_low == 4 * P, "R2 write pulse width", we_low, 4 * P);
        chk(oe_low == 2 * R, "R2 read strobe width", oe_low, 2 * R);
        chk(wr_nowe == 4 * (S + H), "R2 setup plus hold", wr_nowe, 4 * (S + H));
        chk(ce_rise == 6, "R2 chip enable released between cycles", ce_rise, 6);

        // R9: identification outcomes
        mfr_v = 16'h00C2; dev_v = 16'h234B;
        run_req(3'd4, 16'h0000, 16'h0000);
        chk(bad_o == 1'b1, "R9 wrong manufacturer", bad_o, 1);
        mfr_v = 16'h00BF; dev_v = 16'h1234;
        run_req(3'd4, 16'h0000, 16'h0000);
        chk(bad_o == 1'b1, "R9 unknown device", bad_o, 1);
        dev_v = 16'h235A;
        run_req(3'd4, 16'h0000, 16'h0000);
        chk(bad_o == 1'b0 && rd_o == 16'h235A, "R9 R8 accepted device", rd_o, 16'h235A);

        // R1: a request held during a sector erase is ignored
        begin
            logic never_ready;
            int n;
            never_ready = 1'b1;
            @(negedge clk);
            log_n = 0; rd_n = 0;
            req_valid = 1'b1; req_op = 3'd2; req_addr = 16'h0400;
            @(posedge clk);
            @(negedge clk);
            req_op = 3'd0; req_addr = 16'h0005;
            n = 0;
            while (!(rsp_done || rsp_timeout) && n < 3000) begin
                if (req_ready) never_ready = 1'b0;
                @(posedge clk);
                @(negedge clk);
                n = n + 1;
            end
            req_valid = 1'b0;
            chk(never_ready, "R1 ready low while busy", never_ready, 1);
            chk(n == LAT_SECT, "R1 busy request left latency unchanged", n, LAT_SECT);
            chk(log_n == 6 && rd_n == 0, "R1 busy request caused no bus cycle", rd_n, 0);
            @(negedge clk);
            chk(req_ready, "R1 ready after response", req_ready, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule